// File: doc/BRIEF.md
# Four-Channel OS Match Timer

A memory-mapped operating-system timer built around one free-running 32-bit up-counter. The counter moves forward by one on every cycle in which the tick enable is high. Four 32-bit match registers are each compared with the counter. When a tick brings the counter onto a match value and that channel is enabled, the block latches a sticky status bit, and the channel's level interrupt line goes high. Software clears status bits by writing ones to them.

Channel 3 also serves as a watchdog. If the watchdog arm bit is set when channel 3 matches, the block emits a one-cycle system reset request and disarms itself. Software reaches every register through a simple 32-bit request port with a registered read path. The tick source and any bus protocol adaptation sit outside the block.

Top module: `os_match_timer`

## Requirements
- R1: Register offsets: match register n at 4*n (n = 0..3), counter at 0x10, status at 0x14 (bits 3:0, one per channel), watchdog arm at 0x18, interrupt enable at 0x1C. A read request returns the addressed value on rdata_o in the following cycle, and rdata_o holds that value until the next read.
- R2: Each tick advances the counter by one, and the counter wraps from 0xFFFFFFFF to 0.
- R3: A counter write loads the written value. If a tick comes in the same cycle, the load takes priority, and later ticks count on from the loaded value.
- R4: A match happens only on a tick that moves the counter to a value equal to match register n. In that case, if interrupt enable bit n is 1, status bit n is set on the same clock edge. Counter loads and match register writes never produce a match, and a same-cycle match write is compared with the old match value.
- R5: A match on a channel whose enable bit is 0 sets no status bit.
- R6: A match is detected once. While the counter stays equal to a match value with no tick, a cleared status bit stays cleared.
- R7: The interrupt enable register stores only bits 11:0, and bits 31:12 read as zero.
- R8: A status write clears each bit written as 1 and leaves the other bits unchanged. A bit set by a match in the same cycle as a clear stays set.
- R9: irq_o[n] equals status bit n. Clearing the enable bit afterwards does not drop an asserted line.
- R10: If bit 0 of the watchdog arm register is 1 when channel 3 matches, whatever the channel 3 enable bit, wdt_rst_o is high for exactly the following cycle and the arm register becomes 0. A write to the arm register in that same cycle is lost.
- R11: After reset, all match registers, the counter, the status, the interrupt enables and the watchdog arm register read zero.
- R12: A read of an unmapped offset returns 0 and raises err_o for one cycle. A write to an unmapped offset changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Count enable |
| req_i | input | 1 | Register access request |
| we_i | input | 1 | Write (1) or read (0) |
| addr_i | input | 8 | Byte offset |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Registered read data |
| err_o | output | 1 | Unmapped read flag, one cycle |
| irq_o | output | 4 | Per-channel interrupt level |
| wdt_rst_o | output | 1 | Watchdog reset request pulse |

## Verification
Two collisions can fall in the same cycle. A tick can set a status bit while software writes a one to clear that same bit, and a channel 3 watchdog fire can coincide with a software write to the arm register. The bench produces both on purpose and also reaches them through random traffic, in which counter and match values are kept inside a 64-value window. The reference model says the new event survives the clear and that the disarm beats the write. The bench judges each collision by the next interrupt level, the reset pulse and a read-back of the arm register.

// File: rtl/omt_pkg.sv
package omt_pkg;
  localparam int unsigned MATCH_STRIDE = 4;
  localparam int unsigned OFF_CNT      = 'h10;
  localparam int unsigned OFF_STAT     = 'h14;
  localparam int unsigned OFF_WDT      = 'h18;
  localparam int unsigned OFF_IEN      = 'h1C;
endpackage

// File: rtl/omt_counter.sv
module omt_counter #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] cnt_inc_o
);
  logic [CNT_W-1:0] cnt_q;

  assign cnt_inc_o = cnt_q + CNT_W'(1);
  assign cnt_o     = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (load_i) cnt_q <= load_val_i;
    else if (tick_i) cnt_q <= cnt_inc_o;
  end
endmodule

// File: rtl/omt_match_chan.sv
module omt_match_chan #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [CNT_W-1:0] wdata_i,
  input  logic             step_i,
  input  logic [CNT_W-1:0] cnt_inc_i,
  output logic [CNT_W-1:0] match_o,
  output logic             hit_o
);
  logic [CNT_W-1:0] match_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   match_q <= '0;
    else if (wr_i) match_q <= wdata_i;
  end

  // hit only when a tick moves the counter onto the value
  assign hit_o   = step_i && (cnt_inc_i == match_q);
  assign match_o = match_q;
endmodule

// File: rtl/omt_status.sv
module omt_status #(
  parameter int unsigned NUM_CH = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_CH-1:0] set_i,
  input  logic              clr_en_i,
  input  logic [NUM_CH-1:0] clr_mask_i,
  output logic [NUM_CH-1:0] stat_o
);
  logic [NUM_CH-1:0] stat_q;
  logic [NUM_CH-1:0] clr;

  assign clr = clr_en_i ? clr_mask_i : '0;

  // set wins over a same-cycle clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stat_q <= '0;
    else         stat_q <= (stat_q & ~clr) | set_i;
  end

  assign stat_o = stat_q;
endmodule

// File: rtl/os_match_timer.sv
module os_match_timer
  import omt_pkg::*;
#(
  parameter int unsigned NUM_CH = 4,
  parameter int unsigned CNT_W  = 32,
  parameter int unsigned IEN_W  = 12,
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [CNT_W-1:0]  wdata_i,
  output logic [CNT_W-1:0]  rdata_o,
  output logic              err_o,
  output logic [NUM_CH-1:0] irq_o,
  output logic              wdt_rst_o
);
  localparam int unsigned WDT_CH = NUM_CH - 1;

  logic                           wr, rd;
  logic                           sel_cnt, sel_stat, sel_wdt, sel_ien;
  logic [NUM_CH-1:0]              sel_match;
  logic                           cnt_load, step;
  logic [CNT_W-1:0]               cnt_q, cnt_inc;
  logic [NUM_CH-1:0][CNT_W-1:0]   match_q;
  logic [NUM_CH-1:0]              hit;
  logic [NUM_CH-1:0]              stat_q;
  logic [IEN_W-1:0]               ien_q;
  logic [CNT_W-1:0]               wdt_q;
  logic                           wdt_fire;
  logic                           wdt_rst_q;
  logic [CNT_W-1:0]               rd_val;
  logic                           rd_hit;
  logic [CNT_W-1:0]               rdata_q;
  logic                           err_q;

  assign wr = req_i &  we_i;
  assign rd = req_i & ~we_i;

  assign sel_cnt  = (addr_i == ADDR_W'(OFF_CNT));
  assign sel_stat = (addr_i == ADDR_W'(OFF_STAT));
  assign sel_wdt  = (addr_i == ADDR_W'(OFF_WDT));
  assign sel_ien  = (addr_i == ADDR_W'(OFF_IEN));

  assign cnt_load = wr & sel_cnt;
  assign step     = tick_i & ~cnt_load;

  omt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (tick_i),
    .load_i     (cnt_load),
    .load_val_i (wdata_i),
    .cnt_o      (cnt_q),
    .cnt_inc_o  (cnt_inc)
  );

  for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
    assign sel_match[n] = (addr_i == ADDR_W'(n * MATCH_STRIDE));
    omt_match_chan #(.CNT_W(CNT_W)) u_chan (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .wr_i      (wr & sel_match[n]),
      .wdata_i   (wdata_i),
      .step_i    (step),
      .cnt_inc_i (cnt_inc),
      .match_o   (match_q[n]),
      .hit_o     (hit[n])
    );
  end

  omt_status #(.NUM_CH(NUM_CH)) u_stat (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .set_i      (hit & ien_q[NUM_CH-1:0]),
    .clr_en_i   (wr & sel_stat),
    .clr_mask_i (wdata_i[NUM_CH-1:0]),
    .stat_o     (stat_q)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           ien_q <= '0;
    else if (wr & sel_ien) ien_q <= wdata_i[IEN_W-1:0];
  end

  // watchdog: disarm beats a same-cycle write
  assign wdt_fire = hit[WDT_CH] & wdt_q[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wdt_q     <= '0;
      wdt_rst_q <= 1'b0;
    end else begin
      wdt_rst_q <= wdt_fire;
      if (wdt_fire)          wdt_q <= '0;
      else if (wr & sel_wdt) wdt_q <= wdata_i;
    end
  end

  always_comb begin
    rd_val = '0;
    rd_hit = 1'b1;
    if (sel_cnt)       rd_val = cnt_q;
    else if (sel_stat) rd_val = CNT_W'(stat_q);
    else if (sel_wdt)  rd_val = wdt_q;
    else if (sel_ien)  rd_val = CNT_W'(ien_q);
    else begin
      rd_hit = 1'b0;
      for (int n = 0; n < NUM_CH; n++) begin
        if (sel_match[n]) begin
          rd_val = match_q[n];
          rd_hit = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q <= '0;
      err_q   <= 1'b0;
    end else begin
      err_q <= rd & ~rd_hit;
      if (rd) rdata_q <= rd_hit ? rd_val : '0;
    end
  end

  assign rdata_o   = rdata_q;
  assign err_o     = err_q;
  assign irq_o     = stat_q;
  assign wdt_rst_o = wdt_rst_q;
endmodule

// File: rtl/omt_checker.sv
module omt_checker
  import omt_pkg::*;
#(
  parameter int unsigned NUM_CH = 4,
  parameter int unsigned CNT_W  = 32,
  parameter int unsigned IEN_W  = 12,
  parameter int unsigned ADDR_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              tick_i,
  input logic              req_i,
  input logic              we_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [CNT_W-1:0]  cnt_q,
  input logic [IEN_W-1:0]  ien_q,
  input logic [NUM_CH-1:0] stat_q,
  input logic [CNT_W-1:0]  wdt_q,
  input logic [NUM_CH-1:0] irq_o,
  input logic              wdt_rst_o,
  input logic              err_o
);
  logic cnt_wr, stat_wr;
  assign cnt_wr  = req_i && we_i && (addr_i == ADDR_W'(OFF_CNT));
  assign stat_wr = req_i && we_i && (addr_i == ADDR_W'(OFF_STAT));

  a_r2_count_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !cnt_wr) |=> (cnt_q == $past(cnt_q) + CNT_W'(1)));

  a_r8_clear_needs_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !stat_wr |=> ((~stat_q & $past(stat_q)) == '0));

  a_r9_irq_rise_enabled: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((irq_o & ~$past(irq_o) & ~$past(ien_q[NUM_CH-1:0])) == '0));

  a_r10_wdt_disarm: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wdt_rst_o |-> ((wdt_q == '0) && $past(wdt_q[0])));

  a_r12_err_after_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> $past(req_i && !we_i));
endmodule

bind os_match_timer omt_checker #(
  .NUM_CH(NUM_CH), .CNT_W(CNT_W), .IEN_W(IEN_W), .ADDR_W(ADDR_W)
) u_omt_checker (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .tick_i    (tick_i),
  .req_i     (req_i),
  .we_i      (we_i),
  .addr_i    (addr_i),
  .cnt_q     (cnt_q),
  .ien_q     (ien_q),
  .stat_q    (stat_q),
  .wdt_q     (wdt_q),
  .irq_o     (irq_o),
  .wdt_rst_o (wdt_rst_o),
  .err_o     (err_o)
);

// File: tb/tb_os_match_timer.sv
`timescale 1ns/1ps
module tb_os_match_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0, req = 1'b0, we = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        err;
  logic [3:0]  irq;
  logic        wdt_rst;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  // reference state
  logic [31:0] m_cnt, m_wdt;
  logic [31:0] m_match [4];
  logic [11:0] m_ien;
  logic [3:0]  m_stat;

  always #5 clk = ~clk;

  os_match_timer dut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .req_i(req), .we_i(we),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .err_o(err),
    .irq_o(irq), .wdt_rst_o(wdt_rst)
  );

  function automatic bit is_mapped(input logic [7:0] a);
    return (a == 8'h00) || (a == 8'h04) || (a == 8'h08) || (a == 8'h0C) ||
           (a == 8'h10) || (a == 8'h14) || (a == 8'h18) || (a == 8'h1C);
  endfunction

  function automatic logic [31:0] exp_read(input logic [7:0] a);
    case (a)
      8'h00: return m_match[0];
      8'h04: return m_match[1];
      8'h08: return m_match[2];
      8'h0C: return m_match[3];
      8'h10: return m_cnt;
      8'h14: return {28'd0, m_stat};
      8'h18: return m_wdt;
      8'h1C: return {20'd0, m_ien};
      default: return 32'd0;
    endcase
  endfunction

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // one cycle: drive at negedge, model next state, check at next negedge
  task automatic step(input bit tk, input bit rq, input bit w,
                      input logic [7:0] a, input logic [31:0] d, input string tag);
    bit wr, rd, load, fire;
    logic [31:0] inc, rexp;
    logic [3:0] hit, clr;
    tick = tk; req = rq; we = w; addr = a; wdata = d;
    wr = rq && w; rd = rq && !w;
    load = wr && (a == 8'h10);
    inc = m_cnt + 32'd1;
    for (int n = 0; n < 4; n++) hit[n] = tk && !load && (inc == m_match[n]);
    rexp = exp_read(a);
    clr = (wr && a == 8'h14) ? d[3:0] : 4'd0;
    fire = hit[3] && m_wdt[0];
    m_stat = (m_stat & ~clr) | (hit & m_ien[3:0]);
    if (fire) m_wdt = 32'd0;
    else if (wr && a == 8'h18) m_wdt = d;
    if (wr && a == 8'h1C) m_ien = d[11:0];
    for (int n = 0; n < 4; n++) if (wr && a == 8'(n * 4)) m_match[n] = d;
    if (load) m_cnt = d;
    else if (tk) m_cnt = inc;
    @(negedge clk);
    chk(tag, "irq_o", {28'd0, irq}, {28'd0, m_stat});
    chk("R10", "wdt_rst_o", {31'd0, wdt_rst}, {31'd0, fire});
    chk("R12", "err_o", {31'd0, err}, {31'd0, rd && !is_mapped(a)});
    if (rd) chk(tag, $sformatf("rdata_o@%h", a), rdata, rexp);
    tick = 1'b0; req = 1'b0; we = 1'b0;
  endtask

  task automatic wr_reg(input logic [7:0] a, input logic [31:0] d, input string tag);
    step(1'b0, 1'b1, 1'b1, a, d, tag);
  endtask
  task automatic rd_reg(input logic [7:0] a, input string tag);
    step(1'b0, 1'b1, 1'b0, a, 32'd0, tag);
  endtask
  task automatic idle(input bit tk, input string tag);
    step(tk, 1'b0, 1'b0, 8'h00, 32'd0, tag);
  endtask

  initial begin
    m_cnt = '0; m_wdt = '0; m_ien = '0; m_stat = '0;
    for (int n = 0; n < 4; n++) m_match[n] = '0;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R11: reset values; R1: offsets
    for (int i = 0; i < 8; i++) rd_reg(8'(i * 4), "R11");
    // R1: write/read every match register
    for (int n = 0; n < 4; n++) wr_reg(8'(n * 4), 32'hA5A5_0000 + 32'(n), "R1");
    for (int n = 0; n < 4; n++) rd_reg(8'(n * 4), "R1");
    // R7: upper enable bits dropped
    wr_reg(8'h1C, 32'hFFFF_FFFF, "R7");
    rd_reg(8'h1C, "R7");
    wr_reg(8'h1C, 32'h0, "R7");
    // R2: wrap
    wr_reg(8'h10, 32'hFFFF_FFFE, "R3");
    wr_reg(8'h00, 32'h0, "R4");
    wr_reg(8'h1C, 32'h1, "R4");
    idle(1'b1, "R2");
    idle(1'b1, "R2");
    rd_reg(8'h10, "R2");
    wr_reg(8'h14, 32'hF, "R8");
    // R3: load wins over tick, counting resumes
    step(1'b1, 1'b1, 1'b1, 8'h10, 32'd100, "R3");
    idle(1'b1, "R3");
    rd_reg(8'h10, "R3");
    // R4: loading onto the match value is no match
    wr_reg(8'h04, 32'd50, "R4");
    wr_reg(8'h1C, 32'h2, "R4");
    wr_reg(8'h10, 32'd50, "R4");
    rd_reg(8'h14, "R4");
    // R6: match once, no repeat while equal and idle
    wr_reg(8'h10, 32'd9, "R6");
    wr_reg(8'h04, 32'd10, "R6");
    idle(1'b1, "R6");
    wr_reg(8'h14, 32'h2, "R6");
    repeat (4) idle(1'b0, "R6");
    rd_reg(8'h14, "R6");
    // R8: same-cycle set and clear, set survives
    wr_reg(8'h08, 32'd20, "R8");
    wr_reg(8'h1C, 32'h4, "R8");
    wr_reg(8'h10, 32'd19, "R8");
    step(1'b1, 1'b1, 1'b1, 8'h14, 32'h4, "R8");
    // R9: dropping the enable keeps the line
    wr_reg(8'h1C, 32'h0, "R9");
    idle(1'b0, "R9");
    wr_reg(8'h14, 32'h4, "R8");
    // R5: disabled channel
    wr_reg(8'h00, 32'd30, "R5");
    wr_reg(8'h10, 32'd29, "R5");
    idle(1'b1, "R5");
    rd_reg(8'h14, "R5");
    // R10: watchdog fires with channel 3 disabled, then disarmed
    wr_reg(8'h0C, 32'd5, "R10");
    wr_reg(8'h10, 32'd3, "R10");
    wr_reg(8'h18, 32'h1, "R10");
    idle(1'b1, "R10");
    step(1'b1, 1'b1, 1'b1, 8'h18, 32'h1, "R10");  // write lost to disarm
    rd_reg(8'h18, "R10");
    wr_reg(8'h10, 32'd4, "R10");
    idle(1'b1, "R10");
    // R12: unmapped read and write
    rd_reg(8'h24, "R12");
    wr_reg(8'h30, 32'hFFFF_FFFF, "R12");
    for (int i = 0; i < 8; i++) rd_reg(8'(i * 4), "R12");

    // random traffic in a narrow value window
    for (int i = 0; i < 3000; i++) begin
      int unsigned r = $urandom % 16;
      bit tk = ($urandom % 10) < 7;
      case (r)
        0, 1:    step(tk, 1'b1, 1'b1, 8'h10, $urandom % 64, "R3");
        2, 3:    step(tk, 1'b1, 1'b1, 8'(($urandom % 4) * 4), $urandom % 64, "R4");
        4:       step(tk, 1'b1, 1'b1, 8'h1C, $urandom, "R7");
        5:       step(tk, 1'b1, 1'b1, 8'h14, $urandom % 16, "R8");
        6:       step(tk, 1'b1, 1'b1, 8'h18, $urandom % 2, "R10");
        7, 8:    step(tk, 1'b1, 1'b0, 8'(($urandom % 9) * 4), 32'd0, "R1");
        9:       step(tk, 1'b1, ($urandom % 2) == 1, 8'h20 + 8'($urandom % 200), $urandom, "R12");
        default: idle(tk, "R4");
      endcase
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule